// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records the moment an external event happens by copying the value of a free-running 16-bit counter into a capture register. The event comes either from a capture pin or from a comparator output bit, chosen by a select input. The chosen signal passes through a two-flop synchronizer. An optional glitch filter can follow it. An edge detector then fires on rising or falling transitions, as configured.

Each capture raises a flag. The flag drives an interrupt request when the interrupt enable is set. Software clears the flag by writing a one to it, or the interrupt acknowledge clears it. An 8-bit processor bus reaches the 16-bit capture register through one shared temporary byte, so that both halves are seen or changed as a single value. Reads take the low byte first. Writes take the high byte first. A write is accepted only while the counter uses the register as its TOP value.

The counter, the comparator and the waveform logic that picks the TOP mode are outside this block and arrive as plain inputs.

Top module: `stamp_capture_unit`

## Requirements
- R1: With `src_cmp`=1 the event source is `cmp_in` and changes on `pin_in` cause no capture; with `src_cmp`=0 the source is `pin_in` and `cmp_in` is ignored.
- R2: With `rise_sel`=1 only a 0-to-1 change of the source captures; with `rise_sel`=0 only a 1-to-0 change captures.
- R3: With the filter off, a source change that settles before clock edge k is captured at edge k+2. At that edge the capture register takes the full 16-bit `cnt_val` present just before the edge, and `evt_flag` rises on the same edge.
- R4: With `filt_en`=1 a new source level is accepted only after 4 consecutive equal samples. This delays the capture by 4 clocks, to edge k+6. A pulse lasting 3 clocks causes no capture.
- R5: `irq` is 1 exactly when `evt_flag` is 1 and `irq_en` is 1.
- R6: A cycle with `irq_ack`=1 clears `evt_flag`.
- R7: A bus write to address 2 (status) with data bit 0 = 1 clears `evt_flag`. A write with bit 0 = 0 leaves it unchanged. A read of address 2 returns the flag in bit 0.
- R8: If a capture and a flag clear (by write or acknowledge) fall on the same edge, the flag stays set and the new value is stored.
- R9: A read of address 0 returns capture bits 7:0 and copies bits 15:8 into the temporary byte. A read of address 1 returns the temporary byte, even if a capture happened between the two reads.
- R10: With `top_mode`=1, a write to address 1 loads only the temporary byte. A later write to address 0 stores {temporary byte, write data} into the capture register in one step.
- R11: With `top_mode`=0, bus writes to addresses 0 and 1 leave the capture register unchanged.
- R12: After reset the capture register is 0, the flag is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | 16 | Current value of the free-running counter |
| pin_in | input | 1 | External capture pin (asynchronous) |
| cmp_in | input | 1 | Comparator output bit (asynchronous) |
| src_cmp | input | 1 | Source select: 1 = comparator, 0 = pin |
| rise_sel | input | 1 | Edge select: 1 = rising, 0 = falling |
| filt_en | input | 1 | Enables the 4-sample glitch filter |
| irq_en | input | 1 | Interrupt enable |
| top_mode | input | 1 | Counter uses the capture register as TOP; allows bus writes |
| irq_ack | input | 1 | Interrupt acknowledge; clears the flag |
| bus_addr | input | 2 | Register address: 0 = low byte, 1 = high byte, 2 = status |
| bus_wr | input | 1 | Bus write strobe, one cycle |
| bus_rd | input | 1 | Bus read strobe, one cycle |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational from address |
| evt_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
Two cases are hard to reach from the ports, because each needs a bus access timed against the synchronizer delay. In the first, a flag clear arrives on the same edge as a capture. The bench places the write-one so that its strobe covers exactly the second edge after the input change, and it does this while the flag is already set. The second is a read pair split by a capture. The bench reads the low byte, provokes a falling-edge capture with a new counter value, and then reads the high byte. That read must return the half captured earlier, not the new one.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAMP_LO = 2'd0,
        REG_STAMP_HI = 2'd1,
        REG_STATUS   = 2'd2
    } reg_addr_e;

    localparam int unsigned FLAG_BIT = 0;

endpackage

// File: rtl/stamp_conditioner.sv
module stamp_conditioner #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic filt_en,
    output logic level_out
);
    localparam int unsigned RUN_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   held;
        logic [RUN_W-1:0]       run;
    } cond_t;

    cond_t st_d, st_q;
    logic  synced;

    assign synced = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw_in};
        if (synced == st_q.held) begin
            st_d.run = '0;
        end else if (st_q.run == RUN_LAST) begin
            st_d.held = synced;
            st_d.run  = '0;
        end else begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_out = filt_en ? st_q.held : synced;

endmodule

// File: rtl/stamp_edge.sv
module stamp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic rise_sel,
    output logic fire
);
    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t ed_d, ed_q;

    always_comb begin
        ed_d      = ed_q;
        ed_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ed_q <= '0;
        else        ed_q <= ed_d;
    end

    assign fire = rise_sel ? (level & ~ed_q.prev) : (~level & ed_q.prev);

endmodule

// File: rtl/stamp_regs.sv
module stamp_regs
    import stamp_pkg::*;
#(
    parameter int unsigned BUS_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*BUS_W-1:0] cnt_val,
    input  logic               cap_fire,
    input  logic               top_mode,
    input  logic               irq_en,
    input  logic               irq_ack,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic [2*BUS_W-1:0] stamp,
    output logic               flag,
    output logic               irq
);
    localparam int unsigned STAMP_W = 2 * BUS_W;

    typedef struct packed {
        logic [STAMP_W-1:0] stamp;
        logic [BUS_W-1:0]   tmp;
        logic               flag;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  wr_lo, wr_hi, wr_clr, rd_lo;

    always_comb begin
        rd_lo  = bus_rd && (bus_addr == REG_STAMP_LO);
        wr_lo  = bus_wr && (bus_addr == REG_STAMP_LO);
        wr_hi  = bus_wr && (bus_addr == REG_STAMP_HI);
        wr_clr = bus_wr && (bus_addr == REG_STATUS) && bus_wdata[FLAG_BIT];

        rg_d = rg_q;
        if (rd_lo) rg_d.tmp = rg_q.stamp[STAMP_W-1:BUS_W];
        if (wr_hi) rg_d.tmp = bus_wdata;
        if (wr_lo && top_mode) rg_d.stamp = {rg_q.tmp, bus_wdata};
        if (cap_fire) rg_d.stamp = cnt_val;

        if (wr_clr || irq_ack) rg_d.flag = 1'b0;
        if (cap_fire)          rg_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_STAMP_LO: bus_rdata = rg_q.stamp[BUS_W-1:0];
            REG_STAMP_HI: bus_rdata = rg_q.tmp;
            REG_STATUS:   bus_rdata[FLAG_BIT] = rg_q.flag;
            default:      bus_rdata = '0;
        endcase
    end

    assign stamp = rg_q.stamp;
    assign flag  = rg_q.flag;
    assign irq   = rg_q.flag & irq_en;

endmodule

// File: rtl/stamp_capture_unit.sv
module stamp_capture_unit
    import stamp_pkg::*;
#(
    parameter int unsigned BUS_W       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*BUS_W-1:0] cnt_val,
    input  logic               pin_in,
    input  logic               cmp_in,
    input  logic               src_cmp,
    input  logic               rise_sel,
    input  logic               filt_en,
    input  logic               irq_en,
    input  logic               top_mode,
    input  logic               irq_ack,
    input  logic [1:0]         bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               evt_flag,
    output logic               irq
);
    logic               src_raw;
    logic               cond_level;
    logic               cap_fire;
    logic [2*BUS_W-1:0] stamp_val;

    assign src_raw = src_cmp ? cmp_in : pin_in;

    stamp_conditioner #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (src_raw),
        .filt_en  (filt_en),
        .level_out(cond_level)
    );

    stamp_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (cond_level),
        .rise_sel(rise_sel),
        .fire    (cap_fire)
    );

    stamp_regs #(
        .BUS_W(BUS_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_val  (cnt_val),
        .cap_fire (cap_fire),
        .top_mode (top_mode),
        .irq_en   (irq_en),
        .irq_ack  (irq_ack),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .stamp    (stamp_val),
        .flag     (evt_flag),
        .irq      (irq)
    );

endmodule

// File: rtl/stamp_checker.sv
module stamp_checker
    import stamp_pkg::*;
#(
    parameter int unsigned BUS_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*BUS_W-1:0] cnt_val,
    input logic               cap_fire,
    input logic               level,
    input logic               rise_sel,
    input logic               irq_en,
    input logic               irq_ack,
    input logic               top_mode,
    input logic               bus_wr,
    input logic [1:0]         bus_addr,
    input logic [BUS_W-1:0]   bus_wdata,
    input logic [2*BUS_W-1:0] stamp,
    input logic               flag,
    input logic               irq
);
    logic clr_wr;
    assign clr_wr = bus_wr && (bus_addr == REG_STATUS) && bus_wdata[FLAG_BIT];

    assert_stamp_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (stamp == $past(cnt_val)) && flag);

    assert_flag_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(cap_fire));

    assert_polarity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |-> (level == rise_sel));

    assert_irq_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !cap_fire) |=> !flag);

    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !irq_ack && !clr_wr) |=> flag);

    assert_capture_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && (clr_wr || irq_ack)) |=> flag);

    assert_locked_stamp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!top_mode && !cap_fire) |=> $stable(stamp));

endmodule

bind stamp_capture_unit stamp_checker #(.BUS_W(BUS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_val  (cnt_val),
    .cap_fire (cap_fire),
    .level    (cond_level),
    .rise_sel (rise_sel),
    .irq_en   (irq_en),
    .irq_ack  (irq_ack),
    .top_mode (top_mode),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .stamp    (stamp_val),
    .flag     (evt_flag),
    .irq      (irq)
);

// File: tb/stamp_capture_unit_test.sv
module stamp_capture_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        pin_in = 1'b0, cmp_in = 1'b0, src_cmp = 1'b0, rise_sel = 1'b1;
    logic        filt_en = 1'b0, irq_en = 1'b0, top_mode = 1'b0, irq_ack = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        evt_flag, irq;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stamp_capture_unit uut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .pin_in(pin_in), .cmp_in(cmp_in),
        .src_cmp(src_cmp), .rise_sel(rise_sel), .filt_en(filt_en), .irq_en(irq_en),
        .top_mode(top_mode), .irq_ack(irq_ack), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_flag(evt_flag), .irq(irq)
    );

    typedef struct packed {
        logic        src;
        logic        rise;
        logic        filt;
        logic        pin;
        logic        cmp;
        logic [15:0] cnt;
        logic        hit;
    } vec_t;

    localparam vec_t VECS [0:11] = '{
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h1234, 1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h2222, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h3333, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3, 1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h4444, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h5555, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'hBEEF, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h6666, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0F0F, 1'b1},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h7777, 1'b1},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h1111, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'hFFFF, 1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read16(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_read(2'd0, lo);
        bus_read(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic edge_up(input logic [15:0] c);
        pin_in = 1'b0;
        tick(10);
        cnt_val = c;
        pin_in = 1'b1;
        tick(10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog R1..R12 actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;

        tick(3);
        rst_n = 1'b1;
        tick(1);

        irq_en = 1'b1;
        #1;
        check("R12 flag after reset", {31'b0, evt_flag}, 32'd0);
        check("R12 irq after reset", {31'b0, irq}, 32'd0);
        irq_en = 1'b0;
        read16(v);
        check("R12 capture register after reset", {16'b0, v}, 32'd0);

        foreach (VECS[i]) begin
            src_cmp  = VECS[i].src;
            rise_sel = VECS[i].rise;
            filt_en  = VECS[i].filt;
            pin_in   = VECS[i].pin;
            cmp_in   = VECS[i].cmp;
            cnt_val  = VECS[i].cnt;
            tick(12);
            check($sformatf("R1 R2 R4 flag vector %0d", i), {31'b0, evt_flag}, {31'b0, VECS[i].hit});
            if (VECS[i].hit) begin
                read16(v);
                check($sformatf("R3 value vector %0d", i), {16'b0, v}, {16'b0, VECS[i].cnt});
                bus_write(2'd2, 8'h01);
                check($sformatf("R7 clear vector %0d", i), {31'b0, evt_flag}, 32'd0);
            end
        end

        // R3: timing of capture without the filter
        src_cmp = 1'b0; rise_sel = 1'b1; filt_en = 1'b0;
        pin_in = 1'b0;
        tick(8);
        cnt_val = 16'h0100;
        pin_in = 1'b1;
        tick(1);
        check("R3 flag after edge k", {31'b0, evt_flag}, 32'd0);
        cnt_val = 16'h0101;
        tick(1);
        check("R3 flag after edge k+1", {31'b0, evt_flag}, 32'd0);
        cnt_val = 16'h0102;
        tick(1);
        check("R3 flag after edge k+2", {31'b0, evt_flag}, 32'd1);
        read16(v);
        check("R3 value taken at edge k+2", {16'b0, v}, 32'h0102);

        // R5: interrupt gating
        irq_en = 1'b0;
        #1 check("R5 irq masked", {31'b0, irq}, 32'd0);
        irq_en = 1'b1;
        #1 check("R5 irq raised", {31'b0, irq}, 32'd1);

        // R6: acknowledge clears
        tick(1);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        check("R6 flag after ack", {31'b0, evt_flag}, 32'd0);
        check("R6 irq after ack", {31'b0, irq}, 32'd0);
        irq_en = 1'b0;

        // R7: write-zero keeps, write-one clears, status read
        edge_up(16'h0200);
        bus_write(2'd2, 8'hFE);
        check("R7 write zero keeps flag", {31'b0, evt_flag}, 32'd1);
        bus_read(2'd2, b);
        check("R7 status read", {24'b0, b}, 32'h01);
        bus_write(2'd2, 8'h01);
        check("R7 write one clears", {31'b0, evt_flag}, 32'd0);

        // R8: capture and clear on the same edge, flag already set
        edge_up(16'h0200);
        pin_in = 1'b0;
        tick(8);
        cnt_val = 16'h0300;
        pin_in = 1'b1;
        tick(2);
        bus_write(2'd2, 8'h01);
        check("R8 flag survives clear", {31'b0, evt_flag}, 32'd1);
        read16(v);
        check("R8 new value stored", {16'b0, v}, 32'h0300);
        bus_write(2'd2, 8'h01);

        // R4: filter rejects a 3-cycle pulse and delays a capture by 4
        filt_en = 1'b1;
        pin_in = 1'b0;
        tick(12);
        bus_write(2'd2, 8'h01);
        pin_in = 1'b1;
        tick(3);
        pin_in = 1'b0;
        tick(12);
        check("R4 short pulse rejected", {31'b0, evt_flag}, 32'd0);
        cnt_val = 16'h0400;
        pin_in = 1'b1;
        tick(6);
        check("R4 flag after edge k+5", {31'b0, evt_flag}, 32'd0);
        tick(1);
        check("R4 flag after edge k+6", {31'b0, evt_flag}, 32'd1);
        read16(v);
        check("R4 filtered value", {16'b0, v}, 32'h0400);
        bus_write(2'd2, 8'h01);
        filt_en = 1'b0;
        tick(12);

        // R9: low-first read stays paired across a capture
        edge_up(16'h1234);
        bus_read(2'd0, b);
        check("R9 low byte", {24'b0, b}, 32'h34);
        rise_sel = 1'b0;
        cnt_val = 16'h5678;
        pin_in = 1'b0;
        tick(8);
        bus_read(2'd1, b);
        check("R9 high byte from temp", {24'b0, b}, 32'h12);
        read16(v);
        check("R9 new capture pair", {16'b0, v}, 32'h5678);
        rise_sel = 1'b1;
        bus_write(2'd2, 8'h01);

        // R10: high-first write commits on low byte
        top_mode = 1'b1;
        bus_write(2'd1, 8'hAB);
        bus_write(2'd0, 8'hCD);
        read16(v);
        check("R10 committed word", {16'b0, v}, 32'hABCD);
        bus_write(2'd1, 8'h12);
        bus_read(2'd0, b);
        check("R10 high write alone keeps low", {24'b0, b}, 32'hCD);
        bus_read(2'd1, b);
        check("R10 high write alone keeps high", {24'b0, b}, 32'hAB);

        // R11: writes ignored outside TOP mode
        top_mode = 1'b0;
        bus_write(2'd1, 8'h55);
        bus_write(2'd0, 8'h66);
        read16(v);
        check("R11 write ignored", {16'b0, v}, 32'hABCD);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule